// File: doc/BRIEF.md
# Receive Sampling Delay Tuning Sequencer

This block chooses the receive data sampling delay of a high-speed SD/eMMC card link without software stepping through the procedure. On a start request it walks a tune index upward from zero through a fixed number of steps. For each index it presents the value on `tune_o` and loads it into the delay line with a self-clearing update request. The load is repeated a configurable number of times (twice by default) to work around a receive-path timing defect. It then asks the command engine for one tuning block transfer and collects the pass or fail result.

A step fails when either load attempt sees no acknowledgement before a timeout, or when the transfer reports failure. The sequencer keeps the current run of passing steps and the longest run seen so far. When the sweep ends it loads the centre of the longest run. In the HS200 bus mode it then sets the interface mode code and steps the multi-block read gap coefficient upward, requesting one gap test read per value, until a read passes. Bus modes that need no tuning complete at once and change nothing.

Top module: `rx_sample_tuner`

## Requirements
- R1: In a tunable mode, the sweep presents tune indices 0, 1, 2 … 39 in ascending order on `tune_o`, one step per index, and never presents an index above 39 during the sweep.
- R2: Each index is loaded by raising `upd_o` and holding it until `upd_ack_i`. After each acknowledgement `upd_o` goes low for at least one cycle. Two such loads per index are performed before the index's tuning transfer (`xfer_req_o` with `xfer_gap_o`=0) is requested. `upd_o` and `xfer_req_o` are never high together.
- R3: If `upd_ack_i` does not arrive within 16 cycles of `upd_o` rising, `upd_o` drops and the step counts as failed. No further load and no transfer is issued for that index.
- R4: A failed step (load timeout or `xfer_pass_i`=0 at `xfer_done_i`) resets the current run of passes to zero.
- R5: The best run is replaced only by a strictly longer run, recording its length and the index where it ends. Of two runs of equal length, the earlier one is kept.
- R6: After a sweep with at least one pass, the value end − floor(length/2) of the best run is loaded twice (as in R2) and stays on `tune_o`.
- R7: If no step passed, the sequence ends with `err_o`=1, no further load is issued, and `tune_o` keeps the last swept index 39.
- R8: Only `mode_i`=3 (SD SDR104) and `mode_i`=6 (eMMC HS200) run tuning. Every other code raises `done_o` in the cycle after start is taken, with `err_o`=0 and no load or transfer. `tune_o`, `gap_o` and `ifmode_o` keep their previous values.
- R9: After a successful HS200 tune, `ifmode_o` becomes 0x23. `gap_o` then takes 0, 1, … and a gap test read (`xfer_req_o` with `xfer_gap_o`=1) is requested for each value. Stepping stops at the first read that passes, which leaves `gap_o` at that value and `err_o`=0. An SDR104 tune leaves `gap_o` and `ifmode_o` unchanged.
- R10: If every gap read from 0 through 15 fails, the sequence ends with `err_o`=1 and `gap_o`=15.
- R11: `done_o` is high for exactly one cycle at the end of each accepted sequence. `err_o` gives that sequence's outcome in the same cycle.
- R12: A start request while `busy_o` is high is ignored and leaves the running sequence and its result unaffected.
- R13: After reset, `tune_o`, `gap_o`, `ifmode_o`, `busy_o`, `done_o`, `err_o`, `upd_o` and `xfer_req_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| mode_i | input | 3 | Bus timing mode code (3 = SDR104, 6 = HS200) |
| upd_o | output | 1 | Delay-line update request, held until acknowledged |
| upd_ack_i | input | 1 | Update completed (self-clearing bit observed clear) |
| tune_o | output | 6 | Current receive sampling tune index |
| xfer_req_o | output | 1 | Transfer request to the command engine, held until done |
| xfer_gap_o | output | 1 | 1 = gap test read, 0 = tuning block transfer |
| xfer_done_i | input | 1 | Transfer finished, one-cycle pulse |
| xfer_pass_i | input | 1 | Transfer result, valid with `xfer_done_i` |
| ifmode_o | output | 6 | Interface mode code |
| gap_o | output | 4 | Multi-block read gap coefficient |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Outcome of the last sequence (1 = failed) |

## Verification
The hardest case to reach from the ports is a load timeout in the middle of a passing region. Such a timeout splits one window into two, sometimes of equal length, and at the same time removes a transfer from the sequence. The bench's delay-line model withholds `upd_ack_i` for tune indices chosen per run, and its command-engine model answers from a per-index pass mask. Directed masks build equal-length windows, isolated passes at both ends of the range and entirely failing sweeps. Seeded random masks of varying density cover the rest, and an extra start is injected in the middle of a run to confirm it has no effect.

// File: rtl/rxt_pkg.sv
package rxt_pkg;

   // Bus timing mode codes presented on mode_i
   typedef enum logic [2:0] {
      BUS_LEGACY = 3'd0,
      BUS_SDR50  = 3'd1,
      BUS_DDR50  = 3'd2,
      BUS_SDR104 = 3'd3,
      BUS_MMC_HS = 3'd4,
      BUS_MMC_DD = 3'd5,
      BUS_HS200  = 3'd6,
      BUS_HS400  = 3'd7
   } bus_mode_e;

   // Sequencer states
   typedef enum logic [3:0] {
      T_IDLE,
      T_SW_GO,
      T_SW_WAIT,
      T_SW_XFER,
      T_SW_END,
      T_FIN_GO,
      T_FIN_WAIT,
      T_GAP_XFER,
      T_GAP_NEXT
   } tune_st_e;

   // Load unit states
   typedef enum logic [1:0] {
      A_IDLE,
      A_HIGH,
      A_GAP
   } load_st_e;

   function automatic logic mode_tunes(input logic [2:0] m);
      return (m == BUS_SDR104) || (m == BUS_HS200);
   endfunction

endpackage

// File: rtl/rxt_load.sv
module rxt_load
   import rxt_pkg::*;
#(
   parameter int REPS = 2,
   parameter int TMO  = 16
)(
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   input  logic ack_i,
   output logic upd_o,
   output logic fin_o,
   output logic ok_o
);

   localparam int TW = $clog2(TMO + 1);
   localparam int RW = (REPS > 1) ? $clog2(REPS) : 1;

   if (REPS < 1) begin : g_bad_reps
      $error("rxt_load: REPS must be at least 1");
   end
   if (TMO < 1) begin : g_bad_tmo
      $error("rxt_load: TMO must be at least 1");
   end

   load_st_e        st_q;
   logic [TW-1:0]   tmr_q;
   logic            last_rep;
   logic            fin_q;
   logic            ok_q;
   logic            tmr_hit;

   assign tmr_hit = (tmr_q == TW'(TMO - 1));

   if (REPS > 1) begin : g_multi
      logic [RW-1:0] rep_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rep_q <= '0;
         end else if (go_i) begin
            rep_q <= '0;
         end else if (st_q == A_HIGH && ack_i && !last_rep) begin
            rep_q <= rep_q + RW'(1);
         end
      end
      assign last_rep = (rep_q == RW'(REPS - 1));
   end else begin : g_single
      assign last_rep = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= A_IDLE;
         tmr_q <= '0;
         fin_q <= 1'b0;
         ok_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         case (st_q)
            A_IDLE: begin
               if (go_i) begin
                  st_q  <= A_HIGH;
                  tmr_q <= '0;
               end
            end
            A_HIGH: begin
               if (ack_i) begin
                  if (last_rep) begin
                     st_q  <= A_IDLE;
                     fin_q <= 1'b1;
                     ok_q  <= 1'b1;
                  end else begin
                     st_q <= A_GAP;
                  end
               end else if (tmr_hit) begin
                  st_q  <= A_IDLE;
                  fin_q <= 1'b1;
                  ok_q  <= 1'b0;
               end else begin
                  tmr_q <= tmr_q + TW'(1);
               end
            end
            A_GAP: begin
               st_q  <= A_HIGH;
               tmr_q <= '0;
            end
            default: st_q <= A_IDLE;
         endcase
      end
   end

   assign upd_o = (st_q == A_HIGH);
   assign fin_o = fin_q;
   assign ok_o  = ok_q;

   // R3: a silent delay line releases the request and reports failure
   p_tmo_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_o && !ack_i && tmr_hit) |=> (!upd_o && fin_o && !ok_o));

   // R3: the wait counter never passes the timeout
   p_tmr_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |-> (tmr_q < TW'(TMO)));

   // R2: an acknowledged load that is not the last drops the request for a cycle then re-raises
   p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_o && ack_i && !last_rep) |=> (!upd_o && !fin_o) ##1 upd_o);

   p_fin_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fin_o |=> !fin_o);

endmodule

// File: rtl/rxt_window.sv
module rxt_window #(
   parameter int STEPS = 40,
   parameter int IW    = 6
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          upd_i,
   input  logic          pass_i,
   input  logic [IW-1:0] idx_i,
   output logic [$clog2(STEPS+1)-1:0] best_len_o,
   output logic [IW-1:0] centre_o
);

   localparam int LW = $clog2(STEPS + 1);

   if (STEPS < 1 || STEPS > (1 << IW)) begin : g_bad_steps
      $error("rxt_window: STEPS must fit the index width");
   end

   logic [LW-1:0] cur_q;
   logic [LW-1:0] best_q;
   logic [IW-1:0] end_q;
   logic [LW-1:0] cur_nx;

   assign cur_nx = cur_q + LW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         best_q <= '0;
         end_q  <= '0;
      end else if (clr_i) begin
         cur_q  <= '0;
         best_q <= '0;
         end_q  <= '0;
      end else if (upd_i) begin
         if (pass_i) begin
            cur_q <= cur_nx;
            if (cur_nx > best_q) begin
               best_q <= cur_nx;
               end_q  <= idx_i;
            end
         end else begin
            cur_q <= '0;
         end
      end
   end

   assign best_len_o = best_q;
   assign centre_o   = end_q - IW'(best_q >> 1);

   // R5: the running streak never exceeds the recorded best
   p_streak_le_best_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cur_q <= best_q);

   // R5: the best length never shrinks within one sweep
   p_best_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (best_q >= $past(best_q)));

   // R4: a failed step empties the streak
   p_fail_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !pass_i && !clr_i) |=> (cur_q == '0));

endmodule

// File: rtl/rx_sample_tuner.sv
module rx_sample_tuner
   import rxt_pkg::*;
#(
   parameter int TUNE_W     = 6,
   parameter int TUNE_STEPS = 40,
   parameter int GAP_W      = 4,
   parameter int GAP_MAX    = 15,
   parameter int LOAD_REPS  = 2,
   parameter int LOAD_TMO   = 16,
   parameter int IFMODE_W   = 6,
   parameter int IFMODE_VAL = 'h23
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [2:0]          mode_i,
   output logic                upd_o,
   input  logic                upd_ack_i,
   output logic [TUNE_W-1:0]   tune_o,
   output logic                xfer_req_o,
   output logic                xfer_gap_o,
   input  logic                xfer_done_i,
   input  logic                xfer_pass_i,
   output logic [IFMODE_W-1:0] ifmode_o,
   output logic [GAP_W-1:0]    gap_o,
   output logic                busy_o,
   output logic                done_o,
   output logic                err_o
);

   localparam int LW = $clog2(TUNE_STEPS + 1);
   localparam logic [TUNE_W-1:0]   LAST_IDX = TUNE_W'(TUNE_STEPS - 1);
   localparam logic [GAP_W-1:0]    GAP_TOP  = GAP_W'(GAP_MAX);
   localparam logic [IFMODE_W-1:0] IF_CODE  = IFMODE_W'(IFMODE_VAL);

   if (TUNE_STEPS < 1 || TUNE_STEPS > (1 << TUNE_W)) begin : g_bad_steps
      $error("rx_sample_tuner: TUNE_STEPS must fit TUNE_W");
   end
   if (GAP_MAX < 0 || GAP_MAX >= (1 << GAP_W)) begin : g_bad_gap
      $error("rx_sample_tuner: GAP_MAX must fit GAP_W");
   end
   if (IFMODE_VAL >= (1 << IFMODE_W)) begin : g_bad_if
      $error("rx_sample_tuner: IFMODE_VAL must fit IFMODE_W");
   end

   tune_st_e              st_q;
   logic [2:0]            mode_q;
   logic [TUNE_W-1:0]     tval_q;
   logic [GAP_W-1:0]      gap_q;
   logic [IFMODE_W-1:0]   if_q;
   logic                  done_q;
   logic                  err_q;

   logic                  load_go;
   logic                  load_fin;
   logic                  load_ok;
   logic                  win_clr;
   logic                  win_upd;
   logic                  win_pass;
   logic [LW-1:0]         best_len;
   logic [TUNE_W-1:0]     centre;
   logic                  take_start;

   assign take_start = (st_q == T_IDLE) && start_i;
   assign load_go    = (st_q == T_SW_GO) || (st_q == T_FIN_GO);
   assign win_clr    = take_start;
   assign win_upd    = ((st_q == T_SW_WAIT) && load_fin && !load_ok)
                     || ((st_q == T_SW_XFER) && xfer_done_i);
   assign win_pass   = (st_q == T_SW_XFER) && xfer_pass_i;

   rxt_load #(
      .REPS (LOAD_REPS),
      .TMO  (LOAD_TMO)
   ) u_load (
      .clk   (clk),
      .rst_n (rst_n),
      .go_i  (load_go),
      .ack_i (upd_ack_i),
      .upd_o (upd_o),
      .fin_o (load_fin),
      .ok_o  (load_ok)
   );

   rxt_window #(
      .STEPS (TUNE_STEPS),
      .IW    (TUNE_W)
   ) u_window (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (win_clr),
      .upd_i      (win_upd),
      .pass_i     (win_pass),
      .idx_i      (tval_q),
      .best_len_o (best_len),
      .centre_o   (centre)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= T_IDLE;
         mode_q <= '0;
         tval_q <= '0;
         gap_q  <= '0;
         if_q   <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            T_IDLE: begin
               if (start_i) begin
                  mode_q <= mode_i;
                  err_q  <= 1'b0;
                  if (mode_tunes(mode_i)) begin
                     tval_q <= '0;
                     st_q   <= T_SW_GO;
                  end else begin
                     done_q <= 1'b1;
                  end
               end
            end
            T_SW_GO: st_q <= T_SW_WAIT;
            T_SW_WAIT: begin
               if (load_fin && load_ok) begin
                  st_q <= T_SW_XFER;
               end
            end
            T_SW_XFER: ;
            T_SW_END: begin
               if (best_len == '0) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                  st_q   <= T_IDLE;
               end else begin
                  tval_q <= centre;
                  st_q   <= T_FIN_GO;
               end
            end
            T_FIN_GO: st_q <= T_FIN_WAIT;
            T_FIN_WAIT: begin
               if (load_fin) begin
                  if (!load_ok) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                     st_q   <= T_IDLE;
                  end else if (mode_q == BUS_HS200) begin
                     if_q  <= IF_CODE;
                     gap_q <= '0;
                     st_q  <= T_GAP_XFER;
                  end else begin
                     done_q <= 1'b1;
                     st_q   <= T_IDLE;
                  end
               end
            end
            T_GAP_XFER: begin
               if (xfer_done_i) begin
                  if (xfer_pass_i) begin
                     done_q <= 1'b1;
                     st_q   <= T_IDLE;
                  end else if (gap_q == GAP_TOP) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                     st_q   <= T_IDLE;
                  end else begin
                     gap_q <= gap_q + GAP_W'(1);
                     st_q  <= T_GAP_NEXT;
                  end
               end
            end
            T_GAP_NEXT: st_q <= T_GAP_XFER;
            default: st_q <= T_IDLE;
         endcase

         // sweep step end: advance the index or close the sweep
         if (win_upd) begin
            if (tval_q == LAST_IDX) begin
               st_q <= T_SW_END;
            end else begin
               tval_q <= tval_q + TUNE_W'(1);
               st_q   <= T_SW_GO;
            end
         end
      end
   end

   assign tune_o     = tval_q;
   assign gap_o      = gap_q;
   assign ifmode_o   = if_q;
   assign busy_o     = (st_q != T_IDLE);
   assign done_o     = done_q;
   assign err_o      = err_q;
   assign xfer_req_o = (st_q == T_SW_XFER) || (st_q == T_GAP_XFER);
   assign xfer_gap_o = (st_q == T_GAP_XFER);

   // R11: completion is a single-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R11: a new error flag only appears together with completion
   p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> done_o);

   // R2: load and transfer handshakes never overlap
   p_one_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_o && xfer_req_o));

   // R12: a start during a run leaves the captured mode alone
   p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(mode_q));

   // R9: gap reads only happen in HS200 after the mode code is set
   p_gap_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_gap_o |-> ((ifmode_o == IF_CODE) && (mode_q == BUS_HS200)));

   // R8: an idle sequencer drives no handshake
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!upd_o && !xfer_req_o));

   // R1: sweep indices stay inside the swept range
   p_sweep_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req_o && !xfer_gap_o) |-> (tval_q <= LAST_IDX));

endmodule

// File: tb/sim_rx_sample_tuner.sv
module sim_rx_sample_tuner;

   localparam int CLK_PERIOD = 10;
   localparam int STEPS      = 40;

   logic       clk;
   logic       rst_n;
   logic       start_i;
   logic [2:0] mode_i;
   logic       upd_o;
   logic       upd_ack_i;
   logic [5:0] tune_o;
   logic       xfer_req_o;
   logic       xfer_gap_o;
   logic       xfer_done_i;
   logic       xfer_pass_i;
   logic [5:0] ifmode_o;
   logic [3:0] gap_o;
   logic       busy_o;
   logic       done_o;
   logic       err_o;

   rx_sample_tuner u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .mode_i      (mode_i),
      .upd_o       (upd_o),
      .upd_ack_i   (upd_ack_i),
      .tune_o      (tune_o),
      .xfer_req_o  (xfer_req_o),
      .xfer_gap_o  (xfer_gap_o),
      .xfer_done_i (xfer_done_i),
      .xfer_pass_i (xfer_pass_i),
      .ifmode_o    (ifmode_o),
      .gap_o       (gap_o),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .err_o       (err_o)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // stimulus knobs read by the responders
   logic [STEPS-1:0] pass_mask = '0;
   logic [STEPS-1:0] tmo_mask  = '0;
   int               gap_thr   = 0;

   // observations
   int rec_tune [0:255];
   int rec_n     = 0;
   int sweep_xf  = 0;
   int gap_xf    = 0;

   // expected state carried between runs
   int prev_tune = 0;
   int prev_gap  = 0;
   int prev_if   = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // delay-line model: acknowledges after 0..3 cycles unless the index is muted
   bit upd_seen = 0;
   int upd_cnt  = 0;
   always @(negedge clk) begin
      upd_ack_i = 1'b0;
      if (!rst_n || !upd_o) begin
         upd_seen = 0;
      end else begin
         if (!upd_seen) begin
            upd_seen = 1;
            upd_cnt  = int'($urandom % 4);
            if (rec_n < 256) rec_tune[rec_n] = int'(tune_o);
            rec_n++;
         end
         if (!(tune_o < 6'(STEPS) && tmo_mask[tune_o])) begin
            if (upd_cnt == 0) upd_ack_i = 1'b1;
            else upd_cnt--;
         end
      end
   end

   // command-engine model
   bit xf_seen = 0;
   bit xf_sent = 0;
   int xf_cnt  = 0;
   always @(negedge clk) begin
      xfer_done_i = 1'b0;
      xfer_pass_i = 1'b0;
      if (!rst_n || !xfer_req_o) begin
         xf_seen = 0;
         xf_sent = 0;
      end else begin
         if (!xf_seen) begin
            xf_seen = 1;
            xf_cnt  = int'($urandom % 4);
            if (xfer_gap_o) gap_xf++;
            else sweep_xf++;
         end
         if (!xf_sent) begin
            if (xf_cnt == 0) begin
               xf_sent     = 1;
               xfer_done_i = 1'b1;
               if (xfer_gap_o) xfer_pass_i = (int'(gap_o) >= gap_thr);
               else xfer_pass_i = (tune_o < 6'(STEPS)) ? pass_mask[tune_o] : 1'b0;
            end else begin
               xf_cnt--;
            end
         end
      end
   end

   // reference model of the window search (R4, R5, R6)
   function automatic void window_ref(input logic [STEPS-1:0] eff,
                                      output int best, output int fin_idx);
      int cur = 0;
      int last = 0;
      best = 0;
      for (int i = 0; i < STEPS; i++) begin
         if (eff[i]) begin
            cur++;
            if (cur > best) begin
               best = cur;
               last = i;
            end
         end else begin
            cur = 0;
         end
      end
      fin_idx = last - best / 2;
   endfunction

   task automatic run_case(input int m, input logic [STEPS-1:0] pm,
                           input logic [STEPS-1:0] tm, input int thr,
                           input bit inject, input string name);
      int exp_seq [0:255];
      int exp_n = 0;
      int exp_sx = 0;
      int exp_gx = 0;
      int best, fin_idx;
      int e_tune, e_gap, e_if;
      bit e_err;
      bit tunes;
      int cyc;
      bit seq_ok;
      logic [STEPS-1:0] eff;

      eff   = pm & ~tm;
      tunes = (m == 3) || (m == 6);
      window_ref(eff, best, fin_idx);
      e_tune = prev_tune; e_gap = prev_gap; e_if = prev_if; e_err = 0;
      if (tunes) begin
         for (int i = 0; i < STEPS; i++) begin
            exp_seq[exp_n++] = i;
            if (!tm[i]) begin
               exp_seq[exp_n++] = i;
               exp_sx++;
            end
         end
         if (best == 0) begin
            e_err  = 1;
            e_tune = STEPS - 1;
         end else begin
            exp_seq[exp_n++] = fin_idx;
            exp_seq[exp_n++] = fin_idx;
            e_tune = fin_idx;
            if (m == 6) begin
               e_if   = 'h23;
               e_gap  = (thr > 15) ? 15 : thr;
               exp_gx = e_gap + 1;
               e_err  = (thr > 15);
            end
         end
      end

      pass_mask = pm; tmo_mask = tm; gap_thr = thr;
      rec_n = 0; sweep_xf = 0; gap_xf = 0;
      @(negedge clk);
      mode_i  = 3'(m);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cyc = 1;
      while (!done_o && cyc < 8000) begin
         if (inject && cyc == 30) begin
            start_i = 1'b1;
            mode_i  = 3'd0;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      chk(done_o, {name, " R11 done reached"}, int'(done_o), 1);
      if (!tunes) chk(cyc == 1, {name, " R8 immediate done latency"}, cyc, 1);
      chk(int'(tune_o) == e_tune, {name, " R6/R7 tune value"}, int'(tune_o), e_tune);
      chk(int'(gap_o) == e_gap, {name, " R9/R10 gap value"}, int'(gap_o), e_gap);
      chk(int'(ifmode_o) == e_if, {name, " R9 interface mode"}, int'(ifmode_o), e_if);
      chk(err_o == e_err, {name, " R11 error with done"}, int'(err_o), int'(e_err));
      seq_ok = (rec_n == exp_n);
      for (int i = 0; i < exp_n && i < 256; i++) if (rec_tune[i] != exp_seq[i]) seq_ok = 0;
      chk(seq_ok, {name, " R1/R2/R3 load sequence count"}, rec_n, exp_n);
      chk(sweep_xf == exp_sx, {name, " R3 sweep transfers"}, sweep_xf, exp_sx);
      chk(gap_xf == exp_gx, {name, " R9 gap reads"}, gap_xf, exp_gx);
      @(negedge clk);
      chk(!done_o, {name, " R11 done single cycle"}, int'(done_o), 0);
      if (inject) begin
         int extra = 0;
         for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (done_o) extra++;
         end
         chk(extra == 0, {name, " R12 no second completion"}, extra, 0);
      end
      prev_tune = e_tune; prev_gap = e_gap; prev_if = e_if;
   endtask

   function automatic logic [STEPS-1:0] run_bits(input int lo, input int len);
      logic [STEPS-1:0] v = '0;
      for (int i = 0; i < STEPS; i++) if (i >= lo && i < lo + len) v[i] = 1'b1;
      return v;
   endfunction

   initial begin : watchdog
      #(CLK_PERIOD * 180000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int seed_dummy;
      rst_n = 1'b0;
      start_i = 1'b0;
      mode_i = 3'd0;
      upd_ack_i = 1'b0;
      xfer_done_i = 1'b0;
      xfer_pass_i = 1'b0;
      seed_dummy = int'($urandom(32'd7151));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13 reset state
      chk(tune_o == 0 && gap_o == 0 && ifmode_o == 0, "R13 reset data outputs",
          int'(tune_o) + int'(gap_o) + int'(ifmode_o), 0);
      chk(!busy_o && !done_o && !err_o && !upd_o && !xfer_req_o, "R13 reset control outputs",
          int'({busy_o, done_o, err_o, upd_o, xfer_req_o}), 0);

      // directed corners
      run_case(6, '1, '0, 3, 0, "all-pass HS200");
      run_case(3, '0, '0, 0, 0, "none-pass SDR104 R7");
      run_case(6, run_bits(0, 1), '0, 0, 0, "single pass at 0");
      run_case(3, run_bits(39, 1), '0, 0, 0, "single pass at 39");
      run_case(6, run_bits(5, 5) | run_bits(20, 5), '0, 16, 0, "equal windows R5 gap fail R10");
      run_case(3, '1, run_bits(10, 1) | run_bits(30, 1), 0, 0, "timeouts split window R3 R4");
      run_case(6, '1, '1, 0, 0, "all loads time out");
      run_case(6, run_bits(10, 4), '0, 15, 0, "even window gap 15");
      for (int m = 0; m < 8; m++) begin
         if (m != 3 && m != 6) run_case(m, '1, '0, 0, 0, "non-tuning mode R8");
      end
      run_case(6, run_bits(8, 12), '0, 2, 1, "start while busy R12");

      // seeded random runs
      for (int k = 0; k < 24; k++) begin
         logic [STEPS-1:0] pm, tm;
         int sel = int'($urandom % 3);
         int mr  = int'($urandom % 4);
         int m   = (mr < 2) ? 6 : ((mr == 2) ? 3 : int'($urandom % 8));
         pm = {$urandom, $urandom};
         if (sel == 0) pm = pm | {$urandom, $urandom};
         if (sel == 2) pm = run_bits(int'($urandom % 40), int'($urandom % 15))
                          | run_bits(int'($urandom % 40), int'($urandom % 15));
         tm = (k % 4 == 0) ? ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}) : '0;
         run_case(m, pm, tm, int'($urandom % 18), 0, "random R4 R5 R6");
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule